// File: doc/BRIEF.md
# Byte Shift, Rotate and Bit-Test Unit

This block is a purely combinational datapath slice for an 8-bit processor core. It accepts one operand byte, the current flag byte, a 4-bit operation code and a 3-bit bit index. In the same evaluation it returns the transformed byte and the updated flag byte. It has no clock and no state.

The operations are:

- Circular rotates in either direction.
- Rotates through the carry flag in either direction.
- A left shift that fills with zero, and a left shift that fills with one.
- A right shift that keeps the sign bit, and a right shift that fills with zero.
- A single-bit test.

The surrounding core chooses the source operand, decodes instructions and writes back the results. None of that is part of this unit.

The flag byte layout is: sign at bit 7, zero at bit 6, half-carry at bit 4, parity/overflow at bit 2, subtract at bit 1 and carry at bit 0. Bits 5 and 3 are undefined copies, and the unit passes them through unchanged.

Top module: `sru_top`

## Requirements
- R1: Operation code 2 (rotate left through carry) returns {data[6:0], carry_in} and sets carry to data[7]. Code 3 (rotate right through carry) returns {carry_in, data[7:1]} and sets carry to data[0].
- R2: Code 0 (circular left) returns {data[6:0], data[7]} with carry equal to data[7]. Code 1 (circular right) returns {data[0], data[7:1]} with carry equal to data[0].
- R3: Code 4 (left shift, zero fill) returns {data[6:0], 0}. Code 6 (left shift, one fill) returns {data[6:0], 1}. Both set carry to data[7].
- R4: Code 5 (right shift keeping the sign) returns {data[7], data[7:1]}. Code 7 (right shift, zero fill) returns {0, data[7:1]}. Both set carry to data[0].
- R5: For codes 0 to 7, the flags are set as follows:
  - Sign (bit 7) is result bit 7.
  - Zero (bit 6) is set exactly when the result is 0x00.
  - Parity (bit 2) is set exactly when the result has an even number of ones.
  - Half-carry (bit 4) and subtract (bit 1) are cleared.
- R6: For code 8 (bit test), zero, sign and parity (bits 6, 7, 2) are each set exactly when data[bit_sel] is 0. Half-carry is set and subtract is cleared.
- R7: Bit test returns the operand byte unchanged and leaves carry (bit 0) equal to its incoming value.
- R8: For every operation code, flag bits 5 and 3 of the output equal those of the input.
- R9: Codes 9 to 15 are not operations. They return the operand byte and the flag byte both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 8 | Operand byte |
| flags_i | input | 8 | Incoming flag byte (carry at bit 0) |
| op_i | input | 4 | Operation code |
| bit_sel_i | input | 3 | Bit index for the bit test |
| data_o | output | 8 | Transformed byte |
| flags_o | output | 8 | Updated flag byte |

## Verification
Two effects often land in the same evaluation: the carry-out produced by the shift, and the zero/parity flags derived from the shifted result. A shift can push the only set bit into carry while the result becomes zero; for example, 0x80 shifted left gives carry 1 with zero 1. A rotate through carry can also consume the incoming carry while it produces a new one.

The bench provokes both cases by sweeping every operand byte against both carry-in values for every operation code. For the bit test it also sweeps every bit index. For each vector it compares the whole result byte and each flag field against a model written directly from the requirements, so a flag taken from the wrong stage, or an old carry leaking into a result, shows up as a per-field miscompare.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int BYTE_W   = 8;
    localparam int OP_W     = 4;
    localparam int IDX_W    = $clog2(BYTE_W);
    localparam int MSB      = BYTE_W - 1;

    typedef enum logic [OP_W-1:0] {
        OP_ROT_L_CIRC  = 4'd0,
        OP_ROT_R_CIRC  = 4'd1,
        OP_ROT_L_CARRY = 4'd2,
        OP_ROT_R_CARRY = 4'd3,
        OP_SHL_ZERO    = 4'd4,
        OP_SHR_SIGN    = 4'd5,
        OP_SHL_ONE     = 4'd6,
        OP_SHR_ZERO    = 4'd7,
        OP_TEST_BIT    = 4'd8
    } sru_op_e;

    typedef enum logic [1:0] {
        CLS_SHIFT,
        CLS_TEST,
        CLS_NONE
    } sru_class_e;

    // Flag byte, most significant field first.
    typedef struct packed {
        logic sign;
        logic zero;
        logic spare5;
        logic half;
        logic spare3;
        logic parity;
        logic sub;
        logic carry;
    } sru_flags_t;

    function automatic logic even_ones(input logic [BYTE_W-1:0] v);
        return ~(^v);
    endfunction

    function automatic sru_class_e classify(input logic [OP_W-1:0] code);
        if (code < OP_W'(OP_TEST_BIT))
            return CLS_SHIFT;
        else if (code == OP_W'(OP_TEST_BIT))
            return CLS_TEST;
        else
            return CLS_NONE;
    endfunction

endpackage

// File: rtl/sru_shifter.sv
module sru_shifter
    import sru_pkg::*;
(
    input  logic [BYTE_W-1:0] operand,
    input  logic              carry_in,
    input  logic [OP_W-1:0]   code,
    output logic [BYTE_W-1:0] shifted,
    output logic              carry_out
);

    logic top_bit;
    logic low_bit;
    logic left_fill;
    logic right_fill;
    logic go_left;

    assign top_bit = operand[MSB];
    assign low_bit = operand[0];

    // Pick the direction and the bit that enters the vacated end.
    always_comb begin
        go_left    = 1'b1;
        left_fill  = 1'b0;
        right_fill = 1'b0;
        case (sru_op_e'(code))
            OP_ROT_L_CIRC:  begin go_left = 1'b1; left_fill  = top_bit;  end
            OP_ROT_R_CIRC:  begin go_left = 1'b0; right_fill = low_bit;  end
            OP_ROT_L_CARRY: begin go_left = 1'b1; left_fill  = carry_in; end
            OP_ROT_R_CARRY: begin go_left = 1'b0; right_fill = carry_in; end
            OP_SHL_ZERO:    begin go_left = 1'b1; left_fill  = 1'b0;     end
            OP_SHR_SIGN:    begin go_left = 1'b0; right_fill = top_bit;  end
            OP_SHL_ONE:     begin go_left = 1'b1; left_fill  = 1'b1;     end
            OP_SHR_ZERO:    begin go_left = 1'b0; right_fill = 1'b0;     end
            default:        begin go_left = 1'b1; left_fill  = 1'b0;     end
        endcase
    end

    always_comb begin
        if (go_left) begin
            shifted   = {operand[MSB-1:0], left_fill};
            carry_out = top_bit;
        end else begin
            shifted   = {right_fill, operand[MSB:1]};
            carry_out = low_bit;
        end
    end

endmodule

// File: rtl/sru_bit_probe.sv
module sru_bit_probe
    import sru_pkg::*;
(
    input  logic [BYTE_W-1:0] operand,
    input  logic [IDX_W-1:0]  index,
    output logic              bit_clear
);

    logic [BYTE_W-1:0] hit;

    // One lane per bit position: lane g fires when it is selected and the bit is low.
    for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
        assign hit[g] = (index == IDX_W'(g)) & ~operand[g];
    end

    assign bit_clear = |hit;

endmodule

// File: rtl/sru_flag_gen.sv
module sru_flag_gen
    import sru_pkg::*;
(
    input  sru_class_e        kind,
    input  sru_flags_t        prev,
    input  logic [BYTE_W-1:0] shifted,
    input  logic              shift_carry,
    input  logic              bit_clear,
    output sru_flags_t        next
);

    always_comb begin
        next = prev;
        case (kind)
            CLS_SHIFT: begin
                next.sign   = shifted[MSB];
                next.zero   = (shifted == '0);
                next.half   = 1'b0;
                next.parity = even_ones(shifted);
                next.sub    = 1'b0;
                next.carry  = shift_carry;
            end
            CLS_TEST: begin
                next.sign   = bit_clear;
                next.zero   = bit_clear;
                next.half   = 1'b1;
                next.parity = bit_clear;
                next.sub    = 1'b0;
            end
            default: next = prev;
        endcase
    end

endmodule

// File: rtl/sru_top.sv
module sru_top
    import sru_pkg::*;
(
    input  logic [7:0] data_i,
    input  logic [7:0] flags_i,
    input  logic [3:0] op_i,
    input  logic [2:0] bit_sel_i,
    output logic [7:0] data_o,
    output logic [7:0] flags_o
);

    sru_class_e        kind;
    sru_flags_t        prev_flags;
    sru_flags_t        next_flags;
    logic [BYTE_W-1:0] shifted;
    logic              shift_carry;
    logic              bit_clear;

    assign kind       = classify(op_i);
    assign prev_flags = sru_flags_t'(flags_i);

    sru_shifter u_shifter (
        .operand   (data_i),
        .carry_in  (prev_flags.carry),
        .code      (op_i),
        .shifted   (shifted),
        .carry_out (shift_carry)
    );

    sru_bit_probe u_probe (
        .operand   (data_i),
        .index     (bit_sel_i),
        .bit_clear (bit_clear)
    );

    sru_flag_gen u_flags (
        .kind        (kind),
        .prev        (prev_flags),
        .shifted     (shifted),
        .shift_carry (shift_carry),
        .bit_clear   (bit_clear),
        .next        (next_flags)
    );

    assign data_o  = (kind == CLS_SHIFT) ? shifted : data_i;
    assign flags_o = next_flags;

endmodule

// File: rtl/sru_checker.sv
module sru_checker (
    input logic [7:0] data_i,
    input logic [7:0] flags_i,
    input logic [3:0] op_i,
    input logic [2:0] bit_sel_i,
    input logic [7:0] data_o,
    input logic [7:0] flags_o
);

    always_comb begin
        if (op_i == 4'd2)
            a_r1_rot_left_carry: assert (data_o[0] == flags_i[0] && flags_o[0] == data_i[7]);
        if (op_i == 4'd3)
            a_r1_rot_right_carry: assert (data_o[7] == flags_i[0] && flags_o[0] == data_i[0]);
        if (op_i == 4'd1)
            a_r2_circ_right: assert (data_o[7] == data_i[0] && flags_o[0] == data_i[0]);
        if (op_i == 4'd6)
            a_r3_fill_one: assert (data_o[0] == 1'b1 && flags_o[0] == data_i[7]);
        if (op_i == 4'd5)
            a_r4_sign_kept: assert (data_o[7] == data_i[7]);
        if (op_i < 4'd8)
            a_r5_shift_flags: assert (flags_o[4] == 1'b0 && flags_o[1] == 1'b0
                                      && flags_o[6] == (data_o == 8'h00));
        if (op_i == 4'd8)
            a_r6_test_flags: assert (flags_o[4] && !flags_o[1]
                                     && flags_o[6] == !data_i[bit_sel_i]);
        if (op_i == 4'd8)
            a_r7_test_keeps: assert (flags_o[0] == flags_i[0] && data_o == data_i);
        a_r8_spare_bits: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3]);
        if (op_i > 4'd8)
            a_r9_no_op: assert (data_o == data_i && flags_o == flags_i);
    end

endmodule

bind sru_top sru_checker u_sru_checker (
    .data_i    (data_i),
    .flags_i   (flags_i),
    .op_i      (op_i),
    .bit_sel_i (bit_sel_i),
    .data_o    (data_o),
    .flags_o   (flags_o)
);

// File: tb/test_sru_top.sv
`timescale 1ns/1ps
module test_sru_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] data_i, flags_i, data_o, flags_o;
    logic [3:0] op_i;
    logic [2:0] bit_sel_i;

    sru_top i_sru_top (
        .data_i    (data_i),
        .flags_i   (flags_i),
        .op_i      (op_i),
        .bit_sel_i (bit_sel_i),
        .data_o    (data_o),
        .flags_o   (flags_o)
    );

    typedef struct {
        logic [3:0] op;
        logic [7:0] d;
        logic [7:0] f;
        logic [2:0] sel;
        logic [7:0] exp_d;
        logic [7:0] exp_f;
    } item_t;

    item_t sbq[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    function automatic string data_tag(input logic [3:0] op);
        if (op == 4'd2 || op == 4'd3) return "R1";
        if (op == 4'd0 || op == 4'd1) return "R2";
        if (op == 4'd4 || op == 4'd6) return "R3";
        if (op == 4'd5 || op == 4'd7) return "R4";
        if (op == 4'd8) return "R7";
        return "R9";
    endfunction

    function automatic string flag_tag(input logic [3:0] op);
        if (op < 4'd8) return "R5";
        if (op == 4'd8) return "R6";
        return "R9";
    endfunction

    function automatic int ones(input logic [7:0] v);
        int k = 0;
        for (int i = 0; i < 8; i++) if (v[i]) k++;
        return k;
    endfunction

    // Expected-value model written from the requirements.
    function automatic item_t model(input logic [3:0] op, input logic [7:0] d,
                                    input logic [7:0] f, input logic [2:0] sel);
        item_t it;
        logic  c;
        logic  z;
        int    w;
        it.op = op; it.d = d; it.f = f; it.sel = sel;
        w = int'(d);
        c = 1'b0;
        it.exp_d = d;
        case (op)
            4'd0: begin it.exp_d = 8'((w << 1) | (w >> 7)); c = d[7]; end
            4'd1: begin it.exp_d = 8'((w >> 1) | ((w & 1) << 7)); c = d[0]; end
            4'd2: begin it.exp_d = 8'((w << 1) | int'(f[0])); c = d[7]; end
            4'd3: begin it.exp_d = 8'((w >> 1) | (int'(f[0]) << 7)); c = d[0]; end
            4'd4: begin it.exp_d = 8'(w * 2); c = d[7]; end
            4'd5: begin it.exp_d = 8'((w >> 1) | (w & 8'h80)); c = d[0]; end
            4'd6: begin it.exp_d = 8'(w * 2 + 1); c = d[7]; end
            4'd7: begin it.exp_d = 8'(w / 2); c = d[0]; end
            default: it.exp_d = d;
        endcase
        if (op < 4'd8) begin
            it.exp_f = 8'h00;
            it.exp_f[7] = it.exp_d[7];
            it.exp_f[6] = (it.exp_d == 8'd0);
            it.exp_f[2] = (ones(it.exp_d) % 2 == 0);
            it.exp_f[0] = c;
            it.exp_f[5] = f[5];
            it.exp_f[3] = f[3];
        end else if (op == 4'd8) begin
            z = ((w >> sel) & 1) == 0;
            it.exp_f = {z, z, f[5], 1'b1, f[3], z, 1'b0, f[0]};
        end else begin
            it.exp_f = f;
        end
        return it;
    endfunction

    task automatic drive(input logic [3:0] op, input logic [7:0] d,
                         input logic [7:0] f, input logic [2:0] sel);
        @(negedge clk);
        data_i = d; flags_i = f; op_i = op; bit_sel_i = sel;
        sbq.push_back(model(op, d, f, sel));
    endtask

    // Monitor: compare each pending item at the next rising edge.
    always @(posedge clk) begin
        if (sbq.size() > 0) begin
            item_t it;
            bit    bad;
            it  = sbq.pop_front();
            bad = 0;
            n_vec++;
            if (data_o !== it.exp_d) begin
                bad = 1;
                $display("FAIL %s data op=%0d d=%h f=%h sel=%0d: got %h exp %h",
                         data_tag(it.op), it.op, it.d, it.f, it.sel, data_o, it.exp_d);
            end
            if (flags_o[0] !== it.exp_f[0]) begin
                bad = 1;
                $display("FAIL %s carry op=%0d d=%h f=%h: got %b exp %b",
                         (it.op == 4'd8) ? "R7" : data_tag(it.op), it.op, it.d, it.f,
                         flags_o[0], it.exp_f[0]);
            end
            if ({flags_o[7:6], flags_o[4], flags_o[2:1]} !==
                {it.exp_f[7:6], it.exp_f[4], it.exp_f[2:1]}) begin
                bad = 1;
                $display("FAIL %s flags op=%0d d=%h f=%h sel=%0d: got %h exp %h",
                         flag_tag(it.op), it.op, it.d, it.f, it.sel, flags_o, it.exp_f);
            end
            if ({flags_o[5], flags_o[3]} !== {it.exp_f[5], it.exp_f[3]}) begin
                bad = 1;
                $display("FAIL R8 spare bits op=%0d f=%h: got %h exp %h",
                         it.op, it.f, flags_o, it.exp_f);
            end
            if (bad) n_bad++;
        end
    end

    initial begin
        data_i = '0; flags_i = '0; op_i = '0; bit_sel_i = '0;
        // R1 R2 R3 R4 R5 R8: every byte, both carry values, every shift code
        for (int op = 0; op < 8; op++)
            for (int d = 0; d < 256; d++)
                for (int c = 0; c < 2; c++)
                    drive(4'(op), 8'(d), {~8'(d) & 8'hFE} | 8'(c), 3'(d));
        // R6 R7: bit test over every byte, index and carry value
        for (int s = 0; s < 8; s++)
            for (int d = 0; d < 256; d++)
                for (int c = 0; c < 2; c++)
                    drive(4'd8, 8'(d), 8'(d ^ 8'hA5) & 8'hFE | 8'(c), 3'(s));
        // R9: undefined codes leave everything untouched
        for (int op = 9; op < 16; op++)
            for (int d = 0; d < 256; d += 17)
                drive(4'(op), 8'(d), 8'(d * 7 + op), 3'(op));
        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule